// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small accumulator machine with a ten-opcode instruction set. Every memory access goes through an address register and a data register. Each instruction starts with the same four-step fetch. The program counter is copied into the address register, and a synchronous read is issued. The returned word is captured into the data register while the program counter advances by one. The word then moves into the instruction register, where it is split into an opcode and an address field. An execute step follows. Memory-operand instructions add one extra transfer per register hop.

The machine reads and writes one external single-port synchronous memory. Read data appears one cycle after the read enable. It takes input words through a valid/acknowledge pair and presents results with an output strobe. For test, the current control state, program counter and accumulator are visible at the ports, along with a halted flag.

Top module: `acc_cpu_top`

## Requirements
- R1: While reset is held and on the first cycle after it, the program counter and accumulator are 0. The state output is 0 (fetch-address), halted is low, and memRe, memWe, outStrobe and inAck are all low.
- R2: Fetch takes four states (0 address load, 1 read, 2 capture, 3 split), then state 4 (execute). In state 1, memRe is high and memAddr equals the program counter. The program counter rises by exactly 1, on the clock edge that ends state 2.
- R3: An instruction word is 12 bits: opcode in bits 11:8, address in bits 7:0. The opcodes are HLT=0, ADD=1, SUB=2, STA=3, LDA=5, BRA=6, BRZ=7, BRP=8, INP=9, OUT=10.
- R4: ADD and SUB read memory at the operand address and update the accumulator modulo 2^12. LDA loads the accumulator with the word read from memory.
- R5: STA raises memWe for exactly one cycle, with memAddr equal to the operand and memWdata equal to the accumulator. memRe and memWe are never high together.
- R6: INP stays in state 4 while inValid is low. When inValid is high, inAck is high for that cycle, and on the next cycle the accumulator holds inData.
- R7: OUT raises outStrobe for one cycle, only in state 4, with outData equal to the accumulator.
- R8: BRA always loads the program counter with the operand. BRZ does so only when the accumulator is 0. BRP does so only when accumulator bit 11 is 0. An untaken branch falls through to the next address.
- R9: HLT moves to state 9. There, halted stays high, the program counter and accumulator stay frozen, and no memory access occurs until reset.
- R10: Opcodes 4 and 11 to 15 change neither the accumulator nor the program flow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| memAddr | output | 8 | Memory address (address register) |
| memWdata | output | 12 | Memory write data (data register) |
| memRdata | input | 12 | Memory read data, valid one cycle after memRe |
| memRe | output | 1 | Memory read enable |
| memWe | output | 1 | Memory write enable |
| inData | input | 12 | Input port word |
| inValid | input | 1 | Input word available |
| inAck | output | 1 | Input word taken this cycle |
| outData | output | 12 | Output port word (accumulator) |
| outStrobe | output | 1 | Output word valid this cycle |
| halted | output | 1 | Machine stopped by HLT |
| stateDbg | output | 4 | Control state code |
| pcDbg | output | 8 | Program counter |
| accDbg | output | 12 | Accumulator |

## Verification
The bench holds the first input back for several cycles. A design that does not stall would latch a stale word or skip ahead. The test program drives the accumulator negative, to zero and to exactly 0x7FF and 0x800, so that branches on the sign bit and zero land on both sides of their boundary. A swapped or inverted branch test would emit a different output sequence or miss the final store. An undefined opcode sits in the instruction flow, and the halt is watched for several cycles. A design that treated the undefined opcode as a jump or load would corrupt the expected output, and a leaky halt would keep moving the program counter or touching memory.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    OP_HLT = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_STA = 4'd3,
    OP_LDA = 4'd5,
    OP_BRA = 4'd6,
    OP_BRZ = 4'd7,
    OP_BRP = 4'd8,
    OP_INP = 4'd9,
    OP_OUT = 4'd10
  } opcode_e;

  typedef enum logic [3:0] {
    S_FADDR  = 4'd0,
    S_FREAD  = 4'd1,
    S_FCAPT  = 4'd2,
    S_DECODE = 4'd3,
    S_EXEC   = 4'd4,
    S_MREAD  = 4'd5,
    S_MCAPT  = 4'd6,
    S_ALU    = 4'd7,
    S_MWRITE = 4'd8,
    S_HALT   = 4'd9
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  // Register-transfer strobes from control to datapath
  typedef struct packed {
    logic    marFromPc;
    logic    marFromOp;
    logic    mdrFromMem;
    logic    mdrFromAcc;
    logic    pcInc;
    logic    pcFromOp;
    logic    cirFromMdr;
    logic    accFromIn;
    logic    accFromAlu;
    alu_op_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memIn,
  output logic [DATA_W-1:0] result,
  output logic              isZero,
  output logic              isNeg
);

  always_comb begin
    case (op)
      ALU_ADD: result = accIn + memIn;
      ALU_SUB: result = accIn - memIn;
      default: result = memIn;
    endcase
  end

  // Branch tests on the accumulator
  assign isZero = (accIn == '0);
  assign isNeg  = accIn[DATA_W-1];

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [OP_W-1:0]   opcode,
  output logic              accZero,
  output logic              accNeg,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut
);

  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc, aluRes;
  logic [ADDR_W-1:0] operand;

  assign opcode  = cir[DATA_W-1 -: OP_W];
  assign operand = cir[ADDR_W-1:0];

  acc_cpu_alu #(.DATA_W(DATA_W)) alu_i (
    .op     (ctrl.aluOp),
    .accIn  (acc),
    .memIn  (mdr),
    .result (aluRes),
    .isZero (accZero),
    .isNeg  (accNeg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ctrl.marFromPc)       mar <= pc;
      else if (ctrl.marFromOp)  mar <= operand;
      if (ctrl.mdrFromMem)      mdr <= memRdata;
      else if (ctrl.mdrFromAcc) mdr <= acc;
      if (ctrl.pcInc)           pc  <= pc + 1'b1;
      else if (ctrl.pcFromOp)   pc  <= operand;
      if (ctrl.cirFromMdr)      cir <= mdr;
      if (ctrl.accFromIn)       acc <= inData;
      else if (ctrl.accFromAlu) acc <= aluRes;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign pcOut    = pc;
  assign accOut   = acc;

endmodule

// File: rtl/acc_cpu_control.sv
module acc_cpu_control
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            accZero,
  input  logic            accNeg,
  input  logic            inValid,
  output ctrl_t           ctrl,
  output logic            memRe,
  output logic            memWe,
  output logic            inAck,
  output logic            outStrobe,
  output logic            halted,
  output logic [3:0]      stateCode
);

  state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_FADDR;
    else        state <= nxt;
  end

  always_comb begin
    nxt       = state;
    ctrl      = '0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    inAck     = 1'b0;
    outStrobe = 1'b0;
    case (state)
      S_FADDR:  begin ctrl.marFromPc = 1'b1; nxt = S_FREAD; end
      S_FREAD:  begin memRe = 1'b1; nxt = S_FCAPT; end
      S_FCAPT:  begin ctrl.mdrFromMem = 1'b1; ctrl.pcInc = 1'b1; nxt = S_DECODE; end
      S_DECODE: begin ctrl.cirFromMdr = 1'b1; nxt = S_EXEC; end
      S_EXEC: begin
        nxt = S_FADDR;
        case (opcode)
          OP_HLT: nxt = S_HALT;
          OP_ADD, OP_SUB, OP_LDA: begin ctrl.marFromOp = 1'b1; nxt = S_MREAD; end
          OP_STA: begin
            ctrl.marFromOp  = 1'b1;
            ctrl.mdrFromAcc = 1'b1;
            nxt = S_MWRITE;
          end
          OP_BRA: ctrl.pcFromOp = 1'b1;
          OP_BRZ: ctrl.pcFromOp = accZero;
          OP_BRP: ctrl.pcFromOp = !accNeg;
          OP_INP: begin
            if (inValid) begin
              ctrl.accFromIn = 1'b1;
              inAck = 1'b1;
            end else begin
              nxt = S_EXEC;
            end
          end
          OP_OUT:  outStrobe = 1'b1;
          default: nxt = S_FADDR;
        endcase
      end
      S_MREAD: begin memRe = 1'b1; nxt = S_MCAPT; end
      S_MCAPT: begin ctrl.mdrFromMem = 1'b1; nxt = S_ALU; end
      S_ALU: begin
        ctrl.accFromAlu = 1'b1;
        if (opcode == OP_ADD)      ctrl.aluOp = ALU_ADD;
        else if (opcode == OP_SUB) ctrl.aluOp = ALU_SUB;
        else                       ctrl.aluOp = ALU_PASS;
        nxt = S_FADDR;
      end
      S_MWRITE: begin memWe = 1'b1; nxt = S_FADDR; end
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FADDR;
    endcase
  end

  assign halted    = (state == S_HALT);
  assign stateCode = state;

endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRe,
  output logic              memWe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inAck,
  output logic [DATA_W-1:0] outData,
  output logic              outStrobe,
  output logic              halted,
  output logic [3:0]        stateDbg,
  output logic [ADDR_W-1:0] pcDbg,
  output logic [DATA_W-1:0] accDbg
);

  ctrl_t           ctrl;
  logic [OP_W-1:0] opcode;
  logic            accZero, accNeg;

  acc_cpu_control control_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .accZero   (accZero),
    .accNeg    (accNeg),
    .inValid   (inValid),
    .ctrl      (ctrl),
    .memRe     (memRe),
    .memWe     (memWe),
    .inAck     (inAck),
    .outStrobe (outStrobe),
    .halted    (halted),
    .stateCode (stateDbg)
  );

  acc_cpu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) datapath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .memRdata (memRdata),
    .inData   (inData),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode),
    .accZero  (accZero),
    .accNeg   (accNeg),
    .pcOut    (pcDbg),
    .accOut   (accDbg)
  );

  assign outData = accDbg;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memRe,
  input logic              memWe,
  input logic [DATA_W-1:0] inData,
  input logic              inAck,
  input logic              outStrobe,
  input logic              halted,
  input logic [3:0]        stateDbg,
  input logic [ADDR_W-1:0] pcDbg,
  input logic [DATA_W-1:0] accDbg
);

  assert_fetch_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stateDbg == 4'd1) |-> (memRe && memAddr == pcDbg));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stateDbg == 4'd2) |=> (pcDbg == $past(pcDbg) + 1'b1));

  assert_mem_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRe && memWe));

  assert_store_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memWdata == accDbg));

  assert_input_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inAck |=> (accDbg == $past(inData)));

  assert_out_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    outStrobe |-> (stateDbg == 4'd4));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pcDbg) && $stable(accDbg) && !memRe && !memWe));

endmodule

bind acc_cpu_top acc_cpu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) checker_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .memRe     (memRe),
  .memWe     (memWe),
  .inData    (inData),
  .inAck     (inAck),
  .outStrobe (outStrobe),
  .halted    (halted),
  .stateDbg  (stateDbg),
  .pcDbg     (pcDbg),
  .accDbg    (accDbg)
);

// File: tb/acc_cpu_top_tb_top.sv
module acc_cpu_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata, inData, outData, accDbg;
  logic          memRe, memWe, inValid, inAck, outStrobe, halted;
  logic [3:0]    stateDbg;
  logic [AW-1:0] pcDbg;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] expQ [$];
  int checks = 0;
  int fails  = 0;
  int weCount = 0;
  int haltAccess = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_top dut_i (
    .clk(clk), .rst_n(rst_n), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRe(memRe), .memWe(memWe), .inData(inData),
    .inValid(inValid), .inAck(inAck), .outData(outData), .outStrobe(outStrobe),
    .halted(halted), .stateDbg(stateDbg), .pcDbg(pcDbg), .accDbg(accDbg)
  );

  // Synchronous memory model: read data one cycle after memRe
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Monitor: output strobes popped against the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_n && memWe) weCount++;
    if (rst_n && halted && (memRe || memWe)) haltAccess++;
    if (rst_n && outStrobe) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected strobe", 32'(outData), 32'hFFFF);
      end else begin
        check("R7 output word", 32'(outData), 32'(expQ.pop_front()));
      end
    end
  end

  // Driver: offer one input word and wait for its acknowledge (R6)
  task automatic sendInput(input logic [DW-1:0] v);
    @(negedge clk);
    inValid = 1'b1;
    inData  = v;
    forever begin
      #1;
      if (inAck) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=halted");
    finishRun();
  end

  initial begin
    inValid = 1'b0;
    inData  = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // Program (R3 encoding: opcode in bits 11:8, address in 7:0)
    mem[0]  = 12'h900; // INP
    mem[1]  = 12'h332; // STA 50
    mem[2]  = 12'h900; // INP
    mem[3]  = 12'h132; // ADD 50
    mem[4]  = 12'hA00; // OUT -> 12
    mem[5]  = 12'h233; // SUB 51 -> 0xFF8
    mem[6]  = 12'hA00; // OUT
    mem[7]  = 12'h814; // BRP 20 (not taken)
    mem[8]  = 12'h714; // BRZ 20 (not taken)
    mem[9]  = 12'h534; // LDA 52 -> 0
    mem[10] = 12'h70D; // BRZ 13 (taken)
    mem[11] = 12'hA00; // skipped
    mem[12] = 12'h000; // skipped
    mem[13] = 12'h535; // LDA 53 -> 0x7FF
    mem[14] = 12'h810; // BRP 16 (taken)
    mem[15] = 12'hA00; // skipped
    mem[16] = 12'h136; // ADD 54 -> 0x800
    mem[17] = 12'hA00; // OUT
    mem[18] = 12'hC12; // undefined opcode
    mem[19] = 12'h615; // BRA 21
    mem[20] = 12'h000; // skipped
    mem[21] = 12'h337; // STA 55
    mem[22] = 12'hA00; // OUT
    mem[23] = 12'h000; // HLT
    mem[51] = 12'd20;
    mem[52] = 12'd0;
    mem[53] = 12'h7FF;
    mem[54] = 12'd1;
    expQ.push_back(12'd12);
    expQ.push_back(12'hFF8);
    expQ.push_back(12'h800);
    expQ.push_back(12'h800);

    repeat (3) @(negedge clk);
    // R1: values under reset
    check("R1 pc", 32'(pcDbg), 0);
    check("R1 acc", 32'(accDbg), 0);
    check("R1 state", 32'(stateDbg), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 strobes", 32'({memRe, memWe, outStrobe, inAck}), 0);
    rst_n = 1'b1;
    // R2: four fetch states, then execute with PC advanced once
    repeat (4) @(negedge clk);
    check("R2 execute reached", 32'(stateDbg), 4);
    check("R2 pc after fetch", 32'(pcDbg), 1);
    // R6: stall while no input is offered
    repeat (6) @(negedge clk);
    check("R6 stall state", 32'(stateDbg), 4);
    check("R6 no ack", 32'(inAck), 0);
    check("R6 acc untouched", 32'(accDbg), 0);
    sendInput(12'd5);
    sendInput(12'd7);
    while (!halted) @(negedge clk);
    // R9: frozen after halt
    check("R9 halt pc", 32'(pcDbg), 24);
    repeat (8) @(negedge clk);
    check("R9 still halted", 32'(halted), 1);
    check("R9 pc frozen", 32'(pcDbg), 24);
    check("R9 no access", 32'(haltAccess), 0);
    check("R9 state", 32'(stateDbg), 9);
    // R4/R5/R8/R10 through final state
    check("R10 acc after undefined opcode", 32'(accDbg), 12'h800);
    check("R5 store of input", 32'(mem[50]), 5);
    check("R5 final store", 32'(mem[55]), 12'h800);
    check("R5 write count", 32'(weCount), 2);
    check("R4 operand unchanged", 32'(mem[51]), 20);
    check("R7 all outputs seen", 32'(expQ.size()), 0);
    // R8: untaken branches and skipped OUTs would disturb the queue above
    finishRun();
  end

endmodule